// File: doc/BRIEF.md
# Interval Timer Register Interface

This block is the byte-wide host port of a three-channel interval timer. A host talks to it through a 2-bit address, separate write and read strobes, and an 8-bit data bus. Addresses 0, 1 and 2 reach the count registers of the three channels. Address 3 takes control words and cannot be read back. For each channel the block keeps the byte-access mode, the operating mode and the decimal-count flag. It steps through low and high byte transfers in both directions, and it keeps snapshots of counts and status taken by latch commands.

The counting itself lives in three channel cores outside this block. When a count load completes, the block gives the addressed core a one-cycle load strobe and a 16-bit value. It also drives each core's mode and decimal flag. From each core it takes the live count and the output level, and it uses them for live reads, count snapshots and status bytes.

Top module: `tmr_host_port`

## Requirements
- R1: A control word (write to address 3) with bits 7:6 equal to 0, 1 or 2 and bits 5:4 not zero programs that channel. Bits 5:4 set the access mode (01 low byte only, 10 high byte only, 11 low byte then high byte), bits 3:1 set the operating mode and bit 0 sets the decimal flag. The mode and flag appear on `chan_mode`/`chan_bcd` in the cycle after the write, and other channels are unchanged.
- R2: In low-only mode, a data write to a channel pulses its `ld_stb` bit in the cycle after the write, with the value {8'h00, byte}.
- R3: In high-only mode, a data write pulses `ld_stb` in the cycle after the write, with the value {byte, 8'h00}.
- R4: In word mode, the first data write only holds the byte and gives no strobe. The second write pulses `ld_stb` with {second byte, first byte}. After that the next write is again taken as a low byte.
- R5: With nothing latched, reads return the live count: its low byte in low-only mode, its high byte in high-only mode, and in word mode the low byte then the high byte in turn. The read toggle is separate from the write toggle.
- R6: A control word whose bits 5:4 are 00 takes a snapshot of that channel's count. Following reads return the snapshot bytes in the channel's access mode (one byte, or low then high in word mode). Once the snapshot is used up, reads return the live count again.
- R7: A count snapshot request made while an earlier snapshot is not yet fully read is ignored. This holds for a partly read word snapshot too.
- R8: A control word with bits 7:6 equal to 3 is a read-back command. Bits 1, 2 and 3 select channels 0, 1 and 2. When bit 5 is 0 it takes a count snapshot of each selected channel, under R7. When bit 4 is 0 it takes a status snapshot, unless a status snapshot is already pending on that channel.
- R9: The status byte holds the output level in bit 7, 0 in bit 6, the access mode in bits 5:4, the operating mode in bits 3:1 and the decimal flag in bit 0.
- R10: A read first returns a pending status byte, consuming only the status. After that come the count snapshot bytes, and last the live count.
- R11: A read of address 3 returns 0 and changes no channel state.
- R12: A control word that programs a channel clears that channel's pending status and count snapshot and sets both its read and write toggles to the low byte.
- R13: After reset, every channel is in word mode with operating mode 0 and decimal flag 0. Nothing is pending, both toggles point at the low byte, and `ld_stb` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | 2 | Register address: 0 to 2 are channel counts, 3 is the control port |
| wr_en | input | 1 | Write strobe, one access per cycle |
| rd_en | input | 1 | Read strobe, one access per cycle |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid in the same cycle as `rd_en` |
| cnt_in | input | 48 | Live counts from the channel cores, channel c at bits 16c+15:16c |
| out_in | input | 3 | Output levels from the channel cores |
| ld_stb | output | 3 | One-cycle load strobe for each channel |
| ld_val | output | 48 | Load values, channel c at bits 16c+15:16c |
| chan_mode | output | 9 | Operating mode for each channel, channel c at bits 3c+2:3c |
| chan_bcd | output | 3 | Decimal-count flag for each channel |

## Verification
The assertions assume that the host never raises `wr_en` and `rd_en` in the same cycle. They also assume that the channel cores hold `cnt_in` and `out_in` steady around the clock edge at which a snapshot is taken. The bench drives every access as a single strobe in its own cycle and changes the core-side inputs only between accesses. It changes the live counts after each snapshot on purpose, so that snapshot bytes can be told apart from live bytes.

// File: rtl/tmr_pkg.sv
// Package: shared widths and encodings for the timer host port.
// Assumes byte-wide host access and 16-bit channel counts.
package tmr_pkg;
    localparam int BYTE_W = 8;
    localparam int CNT_W  = 2 * BYTE_W;
    localparam int MODE_W = 3;

    // Byte-access mode; ACC_NONE doubles as "no snapshot pending".
    typedef enum logic [1:0] {
        ACC_NONE = 2'd0,
        ACC_LO   = 2'd1,
        ACC_HI   = 2'd2,
        ACC_WORD = 2'd3
    } acc_e;
endpackage

// File: rtl/tmr_cw_decode.sv
// Module: turns one host write into per-channel command strobes.
// Assumes address NCH is the control port and that NCH is at most 3,
// so that the read-back select bits 3:1 cover every channel.
module tmr_cw_decode
    import tmr_pkg::*;
#(
    parameter int NCH = 3
) (
    input  logic              wr_en,
    input  logic [1:0]        addr,
    input  logic [BYTE_W-1:0] wdata,
    output logic [NCH-1:0]    cfg_stb,
    output logic [NCH-1:0]    cnt_snap,
    output logic [NCH-1:0]    st_snap,
    output logic [NCH-1:0]    data_wr,
    output acc_e              cfg_acc,
    output logic [MODE_W-1:0] cfg_mode,
    output logic              cfg_bcd
);
    localparam logic [1:0] CTL_ADDR = 2'(NCH);
    localparam logic [1:0] RB_SEL   = 2'd3;

    logic       is_ctl;
    logic       is_rb;
    logic [1:0] sel;

    // Field split of the control byte.
    always_comb begin
        is_ctl   = wr_en && (addr == CTL_ADDR);
        sel      = wdata[7:6];
        is_rb    = (sel == RB_SEL);
        cfg_acc  = acc_e'(wdata[5:4]);
        cfg_mode = wdata[3:1];
        cfg_bcd  = wdata[0];
    end

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        // Per-channel strobes: program, count snapshot, status snapshot, data.
        always_comb begin
            cfg_stb[c]  = is_ctl && !is_rb && (sel == 2'(c)) && (cfg_acc != ACC_NONE);
            cnt_snap[c] = is_ctl && ((!is_rb && (sel == 2'(c)) && (cfg_acc == ACC_NONE))
                                  || (is_rb && wdata[c+1] && !wdata[5]));
            st_snap[c]  = is_ctl && is_rb && wdata[c+1] && !wdata[4];
            data_wr[c]  = wr_en && (addr == 2'(c));
        end
    end
endmodule

// File: rtl/tmr_chan_regs.sv
// Module: register state of one channel. Holds the configuration, the
// write and read byte toggles, and the count and status snapshots. It
// produces the read byte and the load strobe.
// Assumes data_wr, snapshot and rd_stb never coincide with cfg_stb, and
// that rd_stb never coincides with a write.
module tmr_chan_regs
    import tmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_stb,
    input  acc_e              cfg_acc,
    input  logic [MODE_W-1:0] cfg_mode,
    input  logic              cfg_bcd,
    input  logic              cnt_snap,
    input  logic              st_snap,
    input  logic              data_wr,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              rd_stb,
    input  logic [CNT_W-1:0]  live_cnt,
    input  logic              out_lvl,
    output logic [BYTE_W-1:0] rbyte,
    output logic              ld_stb,
    output logic [CNT_W-1:0]  ld_val,
    output logic [MODE_W-1:0] mode_o,
    output logic              bcd_o
);
    acc_e              acc;
    logic [MODE_W-1:0] mode;
    logic              bcd;
    logic              wr_hi;
    logic              rd_hi;
    logic [BYTE_W-1:0] wr_hold;
    acc_e              snap_st;
    logic [CNT_W-1:0]  snap_val;
    logic              st_pend;
    logic [BYTE_W-1:0] st_val;

    // Read byte selection: status first, then snapshot, then live count.
    always_comb begin
        if (st_pend) begin
            rbyte = st_val;
        end else if (snap_st == ACC_HI) begin
            rbyte = snap_val[CNT_W-1:BYTE_W];
        end else if (snap_st != ACC_NONE) begin
            rbyte = snap_val[BYTE_W-1:0];
        end else if ((acc == ACC_HI) || ((acc == ACC_WORD) && rd_hi)) begin
            rbyte = live_cnt[CNT_W-1:BYTE_W];
        end else begin
            rbyte = live_cnt[BYTE_W-1:0];
        end
    end

    // Channel state update on program, snapshot, data write and read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc      <= ACC_WORD;
            mode     <= '0;
            bcd      <= 1'b0;
            wr_hi    <= 1'b0;
            rd_hi    <= 1'b0;
            wr_hold  <= '0;
            snap_st  <= ACC_NONE;
            snap_val <= '0;
            st_pend  <= 1'b0;
            st_val   <= '0;
            ld_stb   <= 1'b0;
            ld_val   <= '0;
        end else begin
            ld_stb <= 1'b0;
            if (cfg_stb) begin
                acc     <= cfg_acc;
                mode    <= cfg_mode;
                bcd     <= cfg_bcd;
                wr_hi   <= 1'b0;
                rd_hi   <= 1'b0;
                snap_st <= ACC_NONE;
                st_pend <= 1'b0;
            end else begin
                if (cnt_snap && (snap_st == ACC_NONE)) begin
                    snap_val <= live_cnt;
                    snap_st  <= acc;
                end
                if (st_snap && !st_pend) begin
                    st_val  <= {out_lvl, 1'b0, acc, mode, bcd};
                    st_pend <= 1'b1;
                end
                if (data_wr) begin
                    unique case (acc)
                        ACC_LO: begin
                            ld_stb <= 1'b1;
                            ld_val <= {{BYTE_W{1'b0}}, wdata};
                        end
                        ACC_HI: begin
                            ld_stb <= 1'b1;
                            ld_val <= {wdata, {BYTE_W{1'b0}}};
                        end
                        ACC_WORD: begin
                            if (wr_hi) begin
                                ld_stb <= 1'b1;
                                ld_val <= {wdata, wr_hold};
                            end else begin
                                wr_hold <= wdata;
                            end
                            wr_hi <= !wr_hi;
                        end
                        default: ;
                    endcase
                end
                if (rd_stb) begin
                    if (st_pend) begin
                        st_pend <= 1'b0;
                    end else if (snap_st == ACC_WORD) begin
                        snap_st <= ACC_HI;
                    end else if (snap_st != ACC_NONE) begin
                        snap_st <= ACC_NONE;
                    end else if (acc == ACC_WORD) begin
                        rd_hi <= !rd_hi;
                    end
                end
            end
        end
    end

    assign mode_o = mode;
    assign bcd_o  = bcd;

    p_load_after_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ld_stb |-> $past(data_wr));
    p_prog_clears_r12: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_stb |=> (!st_pend && (snap_st == ACC_NONE) && !wr_hi && !rd_hi));
    p_snap_once_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_snap && !cfg_stb && (snap_st != ACC_NONE)) |=> $stable(snap_val));
    p_status_once_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_snap && !cfg_stb && st_pend) |=> $stable(st_val));
    p_status_first_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && st_pend) |=> (snap_st == $past(snap_st)));
endmodule

// File: rtl/tmr_host_port.sv
// Module: top of the timer host port. Decodes host accesses, keeps one
// register slice per channel and muxes the read byte.
// Assumes at most one of wr_en / rd_en per cycle.
module tmr_host_port
    import tmr_pkg::*;
#(
    parameter int NCH = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [1:0]            addr,
    input  logic                  wr_en,
    input  logic                  rd_en,
    input  logic [7:0]            wdata,
    output logic [7:0]            rdata,
    input  logic [NCH*16-1:0]     cnt_in,
    input  logic [NCH-1:0]        out_in,
    output logic [NCH-1:0]        ld_stb,
    output logic [NCH*16-1:0]     ld_val,
    output logic [NCH*3-1:0]      chan_mode,
    output logic [NCH-1:0]        chan_bcd
);
    logic [NCH-1:0]    cfg_stb;
    logic [NCH-1:0]    cnt_snap;
    logic [NCH-1:0]    st_snap;
    logic [NCH-1:0]    data_wr;
    acc_e              cfg_acc;
    logic [MODE_W-1:0] cfg_mode;
    logic              cfg_bcd;
    logic [BYTE_W-1:0] rbyte [NCH];

    tmr_cw_decode #(.NCH(NCH)) u_dec (
        .wr_en    (wr_en),
        .addr     (addr),
        .wdata    (wdata),
        .cfg_stb  (cfg_stb),
        .cnt_snap (cnt_snap),
        .st_snap  (st_snap),
        .data_wr  (data_wr),
        .cfg_acc  (cfg_acc),
        .cfg_mode (cfg_mode),
        .cfg_bcd  (cfg_bcd)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic rd_stb;
        // Read strobe for this channel; writes take precedence.
        always_comb rd_stb = rd_en && !wr_en && (addr == 2'(c));

        tmr_chan_regs u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .cfg_stb  (cfg_stb[c]),
            .cfg_acc  (cfg_acc),
            .cfg_mode (cfg_mode),
            .cfg_bcd  (cfg_bcd),
            .cnt_snap (cnt_snap[c]),
            .st_snap  (st_snap[c]),
            .data_wr  (data_wr[c]),
            .wdata    (wdata),
            .rd_stb   (rd_stb),
            .live_cnt (cnt_in[c*CNT_W +: CNT_W]),
            .out_lvl  (out_in[c]),
            .rbyte    (rbyte[c]),
            .ld_stb   (ld_stb[c]),
            .ld_val   (ld_val[c*CNT_W +: CNT_W]),
            .mode_o   (chan_mode[c*MODE_W +: MODE_W]),
            .bcd_o    (chan_bcd[c])
        );
    end

    // Read mux; the control port reads as zero.
    always_comb begin
        rdata = '0;
        for (int c = 0; c < NCH; c++) begin
            if (addr == 2'(c)) rdata = rbyte[c];
        end
    end

    p_ctl_reads_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && (addr == 2'(NCH))) |-> (rdata == '0));
    p_single_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && rd_en));
endmodule

// File: tb/sim_tmr_host_port.sv
module sim_tmr_host_port;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  addr = '0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic [47:0] cnt_in = '0;
    logic [2:0]  out_in = '0;
    logic [2:0]  ld_stb;
    logic [47:0] ld_val;
    logic [8:0]  chan_mode;
    logic [2:0]  chan_bcd;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    tmr_host_port u0 (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
        .wdata(wdata), .rdata(rdata), .cnt_in(cnt_in), .out_in(out_in),
        .ld_stb(ld_stb), .ld_val(ld_val), .chan_mode(chan_mode), .chan_bcd(chan_bcd)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic chk(string req, logic [63:0] got, logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got=%0h exp=%0h", req, got, exp);
        end
    endtask

    // Write one byte; returns at the next falling edge, after the capture edge.
    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Read one byte in the strobe cycle.
    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        #1 d = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic rd_chk(string req, input logic [1:0] a, input logic [7:0] exp);
        logic [7:0] d;
        rd(a, d);
        chk(req, d, exp);
    endtask

    task automatic t_reset;
        chk("R13 ld_stb", ld_stb, 3'b000);
        chk("R13 mode", chan_mode, 9'h000);
        chk("R13 bcd", chan_bcd, 3'b000);
        cnt_in[47:32] = 16'hA1B2;
        rd_chk("R13 word low first", 2'd2, 8'hB2);
        rd_chk("R13 word then high", 2'd2, 8'hA1);
    endtask

    task automatic t_program;
        wr(2'd3, 8'b01_01_011_1);
        chk("R1 ch1 mode", chan_mode[5:3], 3'd3);
        chk("R1 ch1 bcd", chan_bcd[1], 1'b1);
        chk("R1 others kept", {chan_mode[8:6], chan_mode[2:0], chan_bcd[2], chan_bcd[0]}, 8'h00);
    endtask

    task automatic t_lo_hi_write;
        wr(2'd3, 8'h14);
        wr(2'd0, 8'hA5);
        chk("R2 strobe", ld_stb, 3'b001);
        chk("R2 value", ld_val[15:0], 16'h00A5);
        wr(2'd3, 8'hA0);
        wr(2'd2, 8'h3C);
        chk("R3 strobe", ld_stb, 3'b100);
        chk("R3 value", ld_val[47:32], 16'h3C00);
    endtask

    task automatic t_word_write;
        wr(2'd3, 8'h74);
        wr(2'd1, 8'h34);
        chk("R4 no strobe on first", ld_stb, 3'b000);
        wr(2'd1, 8'h12);
        chk("R4 strobe", ld_stb, 3'b010);
        chk("R4 value", ld_val[31:16], 16'h1234);
        wr(2'd1, 8'h78);
        chk("R4 back to low", ld_stb, 3'b000);
        wr(2'd1, 8'h56);
        chk("R4 second value", ld_val[31:16], 16'h5678);
    endtask

    task automatic t_live_read;
        cnt_in = {16'h2468, 16'hBEEF, 16'h1357};
        rd_chk("R5 word low", 2'd1, 8'hEF);
        wr(2'd1, 8'h11);
        rd_chk("R5 word high, own toggle", 2'd1, 8'hBE);
        rd_chk("R5 word low again", 2'd1, 8'hEF);
        wr(2'd1, 8'h22);
        chk("R5 write toggle kept", ld_val[31:16], 16'h2211);
        rd_chk("R5 low only", 2'd0, 8'h57);
        rd_chk("R5 high only", 2'd2, 8'h24);
    endtask

    task automatic t_latch;
        wr(2'd3, 8'h74);
        cnt_in[31:16] = 16'hCAFE;
        wr(2'd3, 8'h40);
        cnt_in[31:16] = 16'h1122;
        wr(2'd3, 8'h40);
        rd_chk("R6 snap low", 2'd1, 8'hFE);
        wr(2'd3, 8'h40);
        rd_chk("R7 snap high kept", 2'd1, 8'hCA);
        rd_chk("R6 live after snap", 2'd1, 8'h22);
        rd_chk("R6 live high", 2'd1, 8'h11);
    endtask

    task automatic t_readback;
        wr(2'd3, 8'h14);
        out_in = 3'b001;
        cnt_in[15:0] = 16'h0F0E;
        wr(2'd3, 8'hC2);
        cnt_in[15:0] = 16'h0F77;
        rd_chk("R9 status byte", 2'd0, 8'h94);
        rd_chk("R10 snapshot after status", 2'd0, 8'h0E);
        rd_chk("R10 live last", 2'd0, 8'h77);
        wr(2'd3, 8'hE4);
        out_in = 3'b011;
        wr(2'd3, 8'hE4);
        rd_chk("R8 status kept once", 2'd1, 8'h34);
        rd_chk("R8 status only, live next", 2'd1, 8'h22);
        cnt_in = {16'hAB01, 16'hCD02, 16'hEF03};
        wr(2'd3, 8'hDE);
        cnt_in = '0;
        rd_chk("R8 multi ch0", 2'd0, 8'h03);
        rd_chk("R8 multi ch1 low", 2'd1, 8'h02);
        rd_chk("R8 multi ch1 high", 2'd1, 8'hCD);
        rd_chk("R8 multi ch2", 2'd2, 8'hAB);
    endtask

    task automatic t_ctl_read;
        cnt_in[15:0] = 16'h0055;
        wr(2'd3, 8'hE2);
        rd_chk("R11 ctl reads zero", 2'd3, 8'h00);
        rd_chk("R11 state untouched", 2'd0, 8'h94);
        rd_chk("R11 then live", 2'd0, 8'h55);
    endtask

    task automatic t_reprogram;
        cnt_in[31:16] = 16'h7788;
        wr(2'd3, 8'hC4);
        wr(2'd1, 8'h99);
        wr(2'd3, 8'h74);
        rd_chk("R12 pending cleared", 2'd1, 8'h88);
        wr(2'd1, 8'hAB);
        chk("R12 write toggle low", ld_stb, 3'b000);
        wr(2'd1, 8'hCD);
        chk("R12 word reloaded", ld_val[31:16], 16'hCDAB);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_program();
        t_lo_hi_write();
        t_word_write();
        t_live_read();
        t_latch();
        t_readback();
        t_ctl_read();
        t_reprogram();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog got=hang exp=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule